// File: doc/BRIEF.md
# Load/Store Address Check and Data Formatter

This block is the front stage of a scalar load/store unit. Each request carries a base register value, a signed immediate offset, a 6-bit memory opcode, a register index and, for stores, a data word. The block adds the base and the sign-extended offset to form the effective byte address. It checks that the address is aligned for the access size. It then issues one registered memory request, or it raises a trap request or an illegal-opcode flag instead.

For stores, the block replicates the store data across the 32-bit word and produces the byte enables. For loads, it keeps the size, the signedness, the byte lane and the destination index of the last load it issued. When the read word comes back, it extracts the addressed byte or halfword from the little-endian word and extends it to 32 bits. The result is returned together with the destination index one cycle later.

Top module: `ldst_align`

## Requirements
- R1: The memory address `mem_addr_o` equals `base_i` plus `imm_i` sign-extended to ADDR_W bits. All request-side outputs are registered and appear one clock after the request is presented with `req_valid_i` high.
- R2: Load opcodes 0 (byte) and 1 (halfword) sign-extend the loaded value from bit 7 or bit 15 of the selected field.
- R3: Load opcodes 4 (byte) and 5 (halfword) zero-extend the loaded value.
- R4: Load opcode 2 (word) returns the read word unchanged. For every load, `mem_write_o` is 0 and `mem_be_o` is 4'b0000.
- R5: Little-endian lane selection applies to loads. A byte load takes bits [8*a+7:8*a] of the read word, where a is address bits [1:0]. A halfword load takes bits [16*b+15:16*b], where b is address bit 1.
- R6: Store opcode 32 (byte) drives the data byte in all four lanes with `mem_be_o` = 4'b0001 << a. Store opcode 33 (halfword) drives the halfword in both halves with `mem_be_o` = 4'b0011 << a. Store opcode 34 (word) drives the word with `mem_be_o` = 4'b1111. Every store drives `mem_write_o` = 1.
- R7: An access is misaligned if it is a halfword access with address bit 0 set, or a word access with address bits [1:0] not 00. A misaligned access asserts `trap_o` in the cycle where a request would have appeared, and `mem_valid_o` stays 0 in that cycle.
- R8: Any opcode other than 0, 1, 2, 4, 5, 32, 33 or 34 asserts `illegal_o`, with `mem_valid_o` and `trap_o` both 0.
- R9: A cycle with `req_valid_i` low leaves `mem_valid_o`, `trap_o` and `illegal_o` all 0 in the next cycle.
- R10: During reset and in the first cycle after it, `mem_valid_o`, `trap_o`, `illegal_o` and `ld_valid_o` are 0.
- R11: `ld_valid_o` is high exactly one clock after `rdata_valid_i` is high. `ld_dest_o` then carries the register index of the last load that was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| opcode_i | input | 6 | Memory opcode |
| base_i | input | ADDR_W | Base register value |
| imm_i | input | IMM_W | Signed immediate offset |
| reg_idx_i | input | RIDX_W | Load destination index |
| store_data_i | input | 32 | Store source value |
| mem_valid_o | output | 1 | Memory request issued |
| mem_write_o | output | 1 | Request is a store |
| mem_addr_o | output | ADDR_W | Effective byte address |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_be_o | output | 4 | Store byte enables |
| trap_o | output | 1 | Misaligned-access trap request |
| illegal_o | output | 1 | Unknown opcode |
| rdata_valid_i | input | 1 | Read word returned |
| rdata_i | input | 32 | Returned read word |
| ld_valid_o | output | 1 | Formatted load result valid |
| ld_dest_o | output | RIDX_W | Destination index of the result |
| ld_data_o | output | 32 | Extended load result |

## Verification
The bench uses the default parameters: ADDR_W = 32, IMM_W = 16 and RIDX_W = 6. With these, the whole 6-bit opcode space can be swept against all four byte offsets. Each offset is reached through both positive and negative immediates, so every legal, misaligned and illegal combination occurs. Read words with the top bit of each lane set and clear test both sign and zero extension in every lane.

// File: rtl/ldst_align.sv
module ldst_align #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int RIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [5:0]        opcode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [RIDX_W-1:0] reg_idx_i,
  input  logic [31:0]       store_data_i,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_be_o,
  output logic              trap_o,
  output logic              illegal_o,
  input  logic              rdata_valid_i,
  input  logic [31:0]       rdata_i,
  output logic              ld_valid_o,
  output logic [RIDX_W-1:0] ld_dest_o,
  output logic [31:0]       ld_data_o
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] ea;
  logic [1:0]        size;
  logic              is_ld, is_st, sgn, known, mis;
  logic [3:0]        be;
  logic [31:0]       wd;

  assign ea = base_i + {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    is_ld = 1'b0;
    is_st = 1'b0;
    sgn   = 1'b0;
    size  = 2'd0;
    case (opcode_i)
      6'd0:  begin is_ld = 1'b1; sgn = 1'b1; size = 2'd0; end
      6'd1:  begin is_ld = 1'b1; sgn = 1'b1; size = 2'd1; end
      6'd2:  begin is_ld = 1'b1; size = 2'd2; end
      6'd4:  begin is_ld = 1'b1; size = 2'd0; end
      6'd5:  begin is_ld = 1'b1; size = 2'd1; end
      6'd32: begin is_st = 1'b1; size = 2'd0; end
      6'd33: begin is_st = 1'b1; size = 2'd1; end
      6'd34: begin is_st = 1'b1; size = 2'd2; end
      default: ;
    endcase
  end

  assign known = is_ld | is_st;
  assign mis   = (size == 2'd1 && ea[0]) || (size == 2'd2 && ea[1:0] != 2'b00);

  always_comb begin
    case (size)
      2'd0:    begin be = 4'b0001 << ea[1:0]; wd = {4{store_data_i[7:0]}}; end
      2'd1:    begin be = 4'b0011 << ea[1:0]; wd = {2{store_data_i[15:0]}}; end
      default: begin be = 4'b1111;            wd = store_data_i; end
    endcase
    if (!is_st) be = 4'b0000;
  end

  logic [1:0]        c_size, c_lane;
  logic              c_sgn;
  logic [RIDX_W-1:0] c_dest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid_o <= 1'b0;
      mem_write_o <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_be_o    <= '0;
      trap_o      <= 1'b0;
      illegal_o   <= 1'b0;
      c_size      <= '0;
      c_lane      <= '0;
      c_sgn       <= 1'b0;
      c_dest      <= '0;
    end else begin
      mem_valid_o <= req_valid_i && known && !mis;
      trap_o      <= req_valid_i && known && mis;
      illegal_o   <= req_valid_i && !known;
      mem_write_o <= req_valid_i && is_st;
      mem_addr_o  <= ea;
      mem_wdata_o <= is_st ? wd : 32'd0;
      mem_be_o    <= req_valid_i ? be : 4'b0000;
      if (req_valid_i && is_ld && !mis) begin
        c_size <= size;
        c_lane <= ea[1:0];
        c_sgn  <= sgn;
        c_dest <= reg_idx_i;
      end
    end
  end

  logic [31:0] sh, ext;
  assign sh = rdata_i >> {c_lane, 3'b000};

  always_comb begin
    case (c_size)
      2'd0:    ext = {{24{c_sgn & sh[7]}}, sh[7:0]};
      2'd1:    ext = {{16{c_sgn & sh[15]}}, sh[15:0]};
      default: ext = rdata_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid_o <= 1'b0;
      ld_dest_o  <= '0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= rdata_valid_i;
      if (rdata_valid_i) begin
        ld_dest_o <= c_dest;
        ld_data_o <= ext;
      end
    end
  end
endmodule

module ldst_align_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              mem_valid_o,
  input logic              mem_write_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic              trap_o,
  input logic              illegal_o,
  input logic              rdata_valid_i,
  input logic              ld_valid_o
);
  logic [ADDR_W-1:0] imm_x;
  assign imm_x = ADDR_W'(signed'(imm_i));

  a_r1_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> mem_addr_o == $past(base_i) + $past(imm_x));
  a_r4_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_write_o) |-> mem_be_o == 4'b0000);
  a_r6_store_be: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && mem_write_o) |-> ($countones(mem_be_o) == 1 || mem_be_o == 4'b0011 ||
                                      mem_be_o == 4'b1100 || mem_be_o == 4'b1111));
  a_r7_trap_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !mem_valid_o);
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!mem_valid_o && !trap_o));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!mem_valid_o && !trap_o && !illegal_o));
  a_r11_ld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid_i |=> ld_valid_o);
  a_r11_ld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_valid_i |=> !ld_valid_o);
endmodule

bind ldst_align ldst_align_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .base_i(base_i), .imm_i(imm_i),
  .mem_valid_o(mem_valid_o), .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o),
  .mem_be_o(mem_be_o), .trap_o(trap_o), .illegal_o(illegal_o),
  .rdata_valid_i(rdata_valid_i), .ld_valid_o(ld_valid_o)
);

// File: tb/ldst_align_tb.sv
module ldst_align_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [31:0] base_i = '0;
  logic [15:0] imm_i = '0;
  logic [5:0]  reg_idx_i = '0;
  logic [31:0] store_data_i = '0;
  logic        mem_valid_o, mem_write_o, trap_o, illegal_o, ld_valid_o;
  logic [31:0] mem_addr_o, mem_wdata_o, ld_data_o;
  logic [3:0]  mem_be_o;
  logic        rdata_valid_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic [5:0]  ld_dest_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ldst_align u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt_load(input int op, input logic [1:0] a, input logic [31:0] d);
    logic [31:0] b, h;
    b = (d >> (8 * a)) & 32'hFF;
    h = (d >> (16 * a[1])) & 32'hFFFF;
    case (op)
      0: fmt_load = b[7]  ? (b | 32'hFFFF_FF00) : b;
      1: fmt_load = h[15] ? (h | 32'hFFFF_0000) : h;
      4: fmt_load = b;
      5: fmt_load = h;
      default: fmt_load = d;
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rdw [4];
    logic [15:0] imms [2];
    rdw[0] = 32'h8F7E_A15C; rdw[1] = 32'h7F80_01FF;
    rdw[2] = 32'hFFFF_FFFF; rdw[3] = 32'h0123_8765;
    imms[0] = 16'h0011; imms[1] = 16'hFFF5;
    repeat (3) @(negedge clk);
    chk("R10 mem_valid", {31'd0, mem_valid_o}, 32'd0);
    chk("R10 trap", {31'd0, trap_o}, 32'd0);
    chk("R10 illegal", {31'd0, illegal_o}, 32'd0);
    chk("R10 ld_valid", {31'd0, ld_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 post-reset mem_valid", {31'd0, mem_valid_o}, 32'd0);
    chk("R10 post-reset ld_valid", {31'd0, ld_valid_o}, 32'd0);

    for (int op = 0; op < 64; op++) begin
      for (int a = 0; a < 4; a++) begin
        for (int k = 0; k < 2; k++) begin
          logic [31:0] ea, sd, ex_be, ex_wd;
          bit is_ld, is_st, known, mis;
          int sz;
          is_ld = (op == 0 || op == 1 || op == 2 || op == 4 || op == 5);
          is_st = (op == 32 || op == 33 || op == 34);
          known = is_ld || is_st;
          sz = (op == 1 || op == 5 || op == 33) ? 1 : (op == 2 || op == 34) ? 2 : 0;
          ea = 32'h4000_1200 + 32'(a) + 32'(k * 64);
          mis = known && ((sz == 1 && a[0]) || (sz == 2 && a != 0));
          sd = 32'hC3A5_5A00 + 32'(op * 7 + a);
          opcode_i = 6'(op);
          imm_i = imms[k];
          base_i = ea - {{16{imms[k][15]}}, imms[k]};
          reg_idx_i = 6'(op + a + k);
          store_data_i = sd;
          req_valid_i = 1'b1;
          @(negedge clk);
          req_valid_i = 1'b0;
          chk($sformatf("R8 illegal op=%0d", op), {31'd0, illegal_o}, {31'd0, !known});
          chk($sformatf("R7 trap op=%0d a=%0d", op, a), {31'd0, trap_o}, {31'd0, mis});
          chk($sformatf("R7 mem_valid op=%0d a=%0d", op, a), {31'd0, mem_valid_o},
              {31'd0, known && !mis});
          if (known && !mis) begin
            chk($sformatf("R1 addr op=%0d", op), mem_addr_o, ea);
            chk($sformatf("R6 write op=%0d", op), {31'd0, mem_write_o}, {31'd0, is_st});
            if (is_st) begin
              ex_be = (sz == 0) ? (32'd1 << a) : (sz == 1) ? (32'd3 << a) : 32'hF;
              ex_wd = (sz == 0) ? (sd & 32'hFF) * 32'h0101_0101 :
                      (sz == 1) ? (sd & 32'hFFFF) * 32'h0001_0001 : sd;
              chk($sformatf("R6 be op=%0d a=%0d", op, a), {28'd0, mem_be_o}, ex_be);
              chk($sformatf("R6 wdata op=%0d a=%0d", op, a), mem_wdata_o, ex_wd);
            end else begin
              chk($sformatf("R4 load be op=%0d", op), {28'd0, mem_be_o}, 32'd0);
              rdata_i = rdw[(a + k) % 4];
              rdata_valid_i = 1'b1;
              @(negedge clk);
              rdata_valid_i = 1'b0;
              chk($sformatf("R11 ld_valid op=%0d", op), {31'd0, ld_valid_o}, 32'd1);
              chk($sformatf("R11 dest op=%0d", op), {26'd0, ld_dest_o}, 32'(op + a + k));
              chk($sformatf("%s data op=%0d a=%0d", (op == 2) ? "R4" : (op < 2) ? "R2 R5" : "R3 R5", op, a),
                  ld_data_o, fmt_load(op, 2'(a), rdata_i));
            end
          end
          @(negedge clk);
          chk("R9 idle mem_valid", {31'd0, mem_valid_o}, 32'd0);
          chk("R9 idle trap", {31'd0, trap_o | illegal_o}, 32'd0);
          chk("R11 ld quiet", {31'd0, ld_valid_o}, 32'd0);
        end
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule